// File: doc/BRIEF.md
# SD/MMC Host Command Sequencer

This block is the command and response half of an SD/MMC host controller. Software sets it up through a small word-addressed register interface. It loads a 6-bit command index and a 32-bit argument, picks the response type and data options in a control register, and starts or stops the card clock. A command launches as soon as the control register is written, provided the clock is running. Otherwise the command waits until software starts the clock.

The card side is an abstract channel. A one-cycle request strobe presents the index and argument. The card answers later with a response-valid strobe, a byte count and up to sixteen response bytes. The block checks the byte count against the length that the response type needs, and records success or a response timeout in its status. On success it unpacks the bytes into nine 16-bit response entries, which software pops one per read. When the command carries data, a successful response also raises a data-phase enable for the data half of the controller.

A shared interrupt line reports the end-of-command, clock-off and FIFO-request events, each of which can be masked. When DMA is selected, the two FIFO-request events are taken away from the CPU interrupt and drive two DMA request outputs instead.

Top module: `sdcmd_seq`

## Requirements
- R1: Writing word 2 stores the low 6 bits as the command index. Reading word 2 returns the index ORed with 0x0040. Right after reset it reads 0x0040.
- R2: The argument is written as a high half at word 3 and a low half at word 4. Writing one half leaves the other unchanged, and `card_arg` presents the whole 32 bits.
- R3: A write to the control register (word 5, bits [1:0] response type, bit 2 data enable, bit 7 DMA enable, bit 10 hold) clears the timeout bit (status bit 1), the response-ok bit (status bit 13) and the end-command interrupt (bit 2), and keeps clock-enable (status bit 8). If the clock is enabled and the hold bit is clear, `card_req` pulses high for exactly one cycle, in the cycle after the write. Otherwise the command stays pending.
- R4: Writing word 0 with bit 1 set (start clock) sets status bit 8 and clears the clock-off interrupt (bit 4). It also launches a pending command, unless the stored control value has the hold bit set.
- R5: Writing word 0 with bit 0 set (stop clock) clears status bit 8, sets the clock-off interrupt (bit 4) and drops `data_active`. It also abandons a command that is still waiting for its response, so a response that arrives afterwards has no effect. Stop takes precedence when both bits are written together.
- R6: Each response type needs a minimum byte count: type 0 needs 0 bytes, types 1 and 3 need 4, and type 2 needs 16. A response with fewer bytes sets status bit 1, leaves status bit 13 clear, keeps `data_active` low and leaves every response entry reading 0.
- R7: A response with enough bytes sets status bit 13, and it sets `data_active` equal to control bit 2.
- R8: Every accepted response sets the end-command interrupt (bit 2) in the request register (word 7).
- R9: Reads of word 8 pop the response entries in order. Entry n holds byte 2n in bits [7:0] and byte 2n+1 in bits [15:8], with zeros in place of bytes beyond the returned count. After nine pops, further reads return 0. Each new command resets the read position.
- R10: `irq` is high when any request bit (bit 2 end-command, bit 4 clock-off, bit 5 `rx_fifo_req`, bit 6 `tx_fifo_req`) is set while the matching bit of the 13-bit mask (word 6) is clear.
- R11: While control bit 7 (DMA enable) is set, request bits 5 and 6 are excluded from `irq` and drive `dma_rx_req` and `dma_tx_req`. While bit 7 is clear, both DMA outputs are low.
- R12: After reset the status reads 0, the request register reads 0, and `irq`, `card_req` and `data_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the response entry at word 8) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| card_req | output | 1 | One-cycle command request to the card |
| card_idx | output | 6 | Command index presented with the request |
| card_arg | output | 32 | Command argument presented with the request |
| card_rsp_vld | input | 1 | Card response strobe |
| card_rsp_len | input | 5 | Number of response bytes returned (0 to 16) |
| card_rsp_data | input | 128 | Response bytes, byte k in bits [8k+7:8k] |
| rx_fifo_req | input | 1 | Receive FIFO service request from the data half |
| tx_fifo_req | input | 1 | Transmit FIFO service request from the data half |
| data_active | output | 1 | Data phase enabled after a good response |
| irq | output | 1 | CPU interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block with its default parameters: a 6-bit index, 16 response bytes unpacked into nine entries, and a 13-bit mask. With these values the longest response leaves the ninth entry empty, so the read-past-end and zero-fill rules are both exercised. A table of response types paired with byte counts just below, at, and above each type's threshold drives the length check through both its outcomes. Directed cases cover commands held until the clock starts, the hold bit, a stop during a pending response, and the move of FIFO requests between `irq` and the DMA lines.

// File: rtl/sdc_pkg.sv
// Package: register word indices and bit positions shared by the sequencer.
// Assumes a 16-bit register data path.
package sdc_pkg;
    localparam int REG_W = 16;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CLK  = 4'd0,
        A_STAT = 4'd1,
        A_CMD  = 4'd2,
        A_ARGH = 4'd3,
        A_ARGL = 4'd4,
        A_CTL  = 4'd5,
        A_MASK = 4'd6,
        A_IREQ = 4'd7,
        A_RESP = 4'd8
    } reg_addr_e;

    localparam int ST_TOUT   = 1;
    localparam int ST_CLKEN  = 8;
    localparam int ST_RSPOK  = 13;
    localparam int IR_ENDCMD = 2;
    localparam int IR_CLKOFF = 4;
    localparam int IR_RXF    = 5;
    localparam int IR_TXF    = 6;
    localparam int CT_DATA   = 2;
    localparam int CT_DMA    = 7;
    localparam int CT_HOLD   = 10;
    localparam logic [REG_W-1:0] CTL_KEEP = 16'h3dff;

    // Minimum byte count that each response type needs.
    function automatic int rsp_need(input logic [1:0] rtype);
        case (rtype)
            2'd0:    return 0;
            2'd2:    return 16;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/sdc_launch.sv
// Module: decides when a command goes to the card and tracks the wait for
// its response. Assumes that at most one of ctl_wr and clk_start/clk_stop
// is active in a cycle (they share one register address).
module sdc_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_hold_new,
    input  logic ctl_hold_q,
    input  logic clk_en_q,
    input  logic clk_start,
    input  logic clk_stop,
    input  logic rsp_vld,
    output logic launch,
    output logic accept,
    output logic waiting,
    output logic card_req
);
    logic pending_q;
    logic launch_ctl, launch_clk, abort;

    // Launch conditions: a control write with the clock on, or a clock start with a command pending.
    always_comb begin
        launch_ctl = ctl_wr && !ctl_hold_new && clk_en_q;
        launch_clk = clk_start && !clk_stop && pending_q && !ctl_hold_q;
        launch     = launch_ctl || launch_clk;
        abort      = ctl_wr || clk_stop;
        accept     = waiting && rsp_vld && !abort;
    end

    // Pending flag, response-wait flag and the one-cycle request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            waiting   <= 1'b0;
            card_req  <= 1'b0;
        end else begin
            card_req <= launch;
            if (ctl_wr)          pending_q <= !launch_ctl;
            else if (launch_clk) pending_q <= 1'b0;
            if (launch)                waiting <= 1'b1;
            else if (abort || accept)  waiting <= 1'b0;
        end
    end
endmodule

// File: rtl/sdc_rsp_fifo.sv
// Module: unpacks response bytes in pairs into 16-bit entries and pops them
// one per read. Assumes the clear and load inputs are never both active.
module sdc_rsp_fifo #(
    parameter int RSP_BYTES   = 16,
    parameter int RSP_ENTRIES = 9,
    parameter int LEN_W       = 5,
    parameter int PTR_W       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   load,
    input  logic [LEN_W-1:0]       rsp_len,
    input  logic [RSP_BYTES*8-1:0] rsp_data,
    input  logic                   pop,
    output logic [15:0]            dout
);
    logic [15:0]      ent_q [RSP_ENTRIES];
    logic [PTR_W-1:0] ptr_q;

    for (genvar e = 0; e < RSP_ENTRIES; e++) begin : g_ent
        localparam int LO = 2 * e;
        localparam int HI = 2 * e + 1;
        logic [7:0] lo_b, hi_b;
        if (LO < RSP_BYTES) begin : g_lo
            assign lo_b = (int'(rsp_len) > LO) ? rsp_data[LO*8 +: 8] : 8'h00;
        end else begin : g_lo0
            assign lo_b = 8'h00;
        end
        if (HI < RSP_BYTES) begin : g_hi
            assign hi_b = (int'(rsp_len) > HI) ? rsp_data[HI*8 +: 8] : 8'h00;
        end else begin : g_hi0
            assign hi_b = 8'h00;
        end
        // Entry storage: zeroed at launch, filled by a good response.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) ent_q[e] <= '0;
            else if (load)       ent_q[e] <= {hi_b, lo_b};
        end
    end

    // Read position: restarts with each command and each load, stops past the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || load)                   ptr_q <= '0;
        else if (pop && ptr_q < PTR_W'(RSP_ENTRIES))   ptr_q <= ptr_q + 1'b1;
    end

    // Output the current entry, or zero once all entries have been read.
    always_comb begin
        dout = 16'h0000;
        for (int i = 0; i < RSP_ENTRIES; i++)
            if (ptr_q == PTR_W'(i)) dout = ent_q[i];
    end
endmodule

// File: rtl/sdc_irq_route.sv
// Module: combines request bits with the mask into the CPU interrupt and
// moves the FIFO requests onto the DMA lines when DMA is selected.
module sdc_irq_route #(
    parameter int MASK_W = 13,
    parameter int RXF    = 5,
    parameter int TXF    = 6
) (
    input  logic [MASK_W-1:0] ireq,
    input  logic [MASK_W-1:0] mask,
    input  logic              dma_en,
    output logic              irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    logic [MASK_W-1:0] eff_mask;

    // Effective mask: DMA mode also hides both FIFO request bits from the CPU.
    always_comb begin
        eff_mask = mask;
        if (dma_en) begin
            eff_mask[RXF] = 1'b1;
            eff_mask[TXF] = 1'b1;
        end
        irq        = |(ireq & ~eff_mask);
        dma_rx_req = dma_en && ireq[RXF];
        dma_tx_req = dma_en && ireq[TXF];
    end
endmodule

// File: rtl/sdcmd_seq.sv
// Module: top level of the command sequencer. It holds the registers,
// decodes the register accesses and connects the launch logic, the response
// unpacker and the interrupt routing. Assumes one register access per cycle.
module sdcmd_seq #(
    parameter int IDX_W       = 6,
    parameter int RSP_BYTES   = 16,
    parameter int RSP_ENTRIES = 9,
    parameter int MASK_W      = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [3:0]             reg_addr,
    input  logic [15:0]            reg_wdata,
    output logic [15:0]            reg_rdata,
    output logic                   card_req,
    output logic [IDX_W-1:0]       card_idx,
    output logic [31:0]            card_arg,
    input  logic                   card_rsp_vld,
    input  logic [$clog2(RSP_BYTES+1)-1:0] card_rsp_len,
    input  logic [RSP_BYTES*8-1:0] card_rsp_data,
    input  logic                   rx_fifo_req,
    input  logic                   tx_fifo_req,
    output logic                   data_active,
    output logic                   irq,
    output logic                   dma_rx_req,
    output logic                   dma_tx_req
);
    import sdc_pkg::*;

    localparam int LEN_W = $clog2(RSP_BYTES + 1);
    localparam int PTR_W = $clog2(RSP_ENTRIES + 1);

    logic [IDX_W-1:0]  cmd_q;
    logic [31:0]       arg_q;
    logic [15:0]       ctrl_q;
    logic [MASK_W-1:0] mask_q;
    logic clk_en_q, tout_q, rspok_q, endcmd_q, clkoff_q;
    logic wr_clk, clk_start, clk_stop, ctl_wr, launch, accept, waiting, len_ok;
    logic [15:0]       status_q, resp_dout;
    logic [MASK_W-1:0] ireq_q;

    // Write decode for the clock-control and control registers.
    always_comb begin
        wr_clk    = reg_wr && reg_addr == A_CLK;
        clk_start = wr_clk && reg_wdata[1];
        clk_stop  = wr_clk && reg_wdata[0];
        ctl_wr    = reg_wr && reg_addr == A_CTL;
        len_ok    = int'(card_rsp_len) >= rsp_need(ctrl_q[1:0]);
    end

    // Software-loaded registers: index, argument halves, control and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            arg_q  <= '0;
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CMD:  cmd_q         <= reg_wdata[IDX_W-1:0];
                A_ARGH: arg_q[31:16]  <= reg_wdata;
                A_ARGL: arg_q[15:0]   <= reg_wdata;
                A_CTL:  ctrl_q        <= reg_wdata & CTL_KEEP;
                A_MASK: mask_q        <= reg_wdata[MASK_W-1:0];
                default: ;
            endcase
        end
    end

    // Clock enable and clock-off request: stop takes precedence over start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
            clkoff_q <= 1'b0;
        end else if (clk_stop) begin
            clk_en_q <= 1'b0;
            clkoff_q <= 1'b1;
        end else if (clk_start) begin
            clk_en_q <= 1'b1;
            clkoff_q <= 1'b0;
        end
    end

    // Command outcome: timeout, response-ok, end-command and the data-phase enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tout_q      <= 1'b0;
            rspok_q     <= 1'b0;
            endcmd_q    <= 1'b0;
            data_active <= 1'b0;
        end else begin
            if (ctl_wr) begin
                tout_q   <= 1'b0;
                rspok_q  <= 1'b0;
                endcmd_q <= 1'b0;
            end else if (accept) begin
                endcmd_q <= 1'b1;
                tout_q   <= !len_ok;
                rspok_q  <= len_ok;
            end
            if (ctl_wr || clk_stop || launch) data_active <= 1'b0;
            else if (accept && len_ok)        data_active <= ctrl_q[CT_DATA];
        end
    end

    // Assemble the status word and the request register view.
    always_comb begin
        status_q = '0;
        status_q[ST_TOUT]  = tout_q;
        status_q[ST_CLKEN] = clk_en_q;
        status_q[ST_RSPOK] = rspok_q;
        ireq_q = '0;
        ireq_q[IR_ENDCMD] = endcmd_q;
        ireq_q[IR_CLKOFF] = clkoff_q;
        ireq_q[IR_RXF]    = rx_fifo_req;
        ireq_q[IR_TXF]    = tx_fifo_req;
    end

    // Read data multiplexer.
    always_comb begin
        case (reg_addr)
            A_STAT:  reg_rdata = status_q;
            A_CMD:   reg_rdata = 16'(cmd_q) | 16'h0040;
            A_ARGH:  reg_rdata = arg_q[31:16];
            A_ARGL:  reg_rdata = arg_q[15:0];
            A_CTL:   reg_rdata = ctrl_q;
            A_MASK:  reg_rdata = 16'(mask_q);
            A_IREQ:  reg_rdata = 16'(ireq_q);
            A_RESP:  reg_rdata = resp_dout;
            default: reg_rdata = 16'h0000;
        endcase
    end

    assign card_idx = cmd_q;
    assign card_arg = arg_q;

    sdc_launch u_launch (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .ctl_hold_new (reg_wdata[CT_HOLD]),
        .ctl_hold_q   (ctrl_q[CT_HOLD]),
        .clk_en_q     (clk_en_q),
        .clk_start    (clk_start),
        .clk_stop     (clk_stop),
        .rsp_vld      (card_rsp_vld),
        .launch       (launch),
        .accept       (accept),
        .waiting      (waiting),
        .card_req     (card_req)
    );

    sdc_rsp_fifo #(
        .RSP_BYTES   (RSP_BYTES),
        .RSP_ENTRIES (RSP_ENTRIES),
        .LEN_W       (LEN_W),
        .PTR_W       (PTR_W)
    ) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (launch),
        .load     (accept && len_ok),
        .rsp_len  (card_rsp_len),
        .rsp_data (card_rsp_data),
        .pop      (reg_rd && reg_addr == A_RESP),
        .dout     (resp_dout)
    );

    sdc_irq_route #(
        .MASK_W (MASK_W),
        .RXF    (IR_RXF),
        .TXF    (IR_TXF)
    ) u_irq (
        .ireq       (ireq_q),
        .mask       (mask_q),
        .dma_en     (ctrl_q[CT_DMA]),
        .irq        (irq),
        .dma_rx_req (dma_rx_req),
        .dma_tx_req (dma_tx_req)
    );
endmodule

// File: rtl/sdcmd_seq_chk.sv
// Module: checker for the sequencer. Bound into every instance; it observes
// the ports and the outcome registers over time.
module sdcmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [3:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        card_req,
    input logic        card_rsp_vld,
    input logic [4:0]  card_rsp_len,
    input logic        waiting,
    input logic [15:0] ctrl_q,
    input logic [15:0] status_q,
    input logic [12:0] ireq_q,
    input logic        data_active
);
    logic stop_w, start_w, ctl_w, taken, short_rsp;

    always_comb begin
        stop_w    = reg_wr && reg_addr == 4'd0 && reg_wdata[0];
        start_w   = reg_wr && reg_addr == 4'd0 && reg_wdata[1] && !reg_wdata[0];
        ctl_w     = reg_wr && reg_addr == 4'd5;
        taken     = waiting && card_rsp_vld && !ctl_w && !stop_w;
        short_rsp = (ctrl_q[1:0] == 2'd2) ? (card_rsp_len < 5'd16)
                  : (ctrl_q[1:0] != 2'd0 && card_rsp_len < 5'd4);
    end

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |=> !card_req);
    // R3
    ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_w |=> !status_q[1] && !status_q[13] && !ireq_q[2]);
    // R4
    clk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> status_q[8] && !ireq_q[4]);
    // R5
    clk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> !status_q[8] && ireq_q[4] && !data_active && !waiting);
    // R6
    short_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken && short_rsp |=> status_q[1] && !status_q[13] && !data_active);
    // R7
    good_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken && !short_rsp |=> status_q[13] && !status_q[1]);
    // R8
    end_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> ireq_q[2]);
endmodule

bind sdcmd_seq sdcmd_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .card_req     (card_req),
    .card_rsp_vld (card_rsp_vld),
    .card_rsp_len (card_rsp_len),
    .waiting      (waiting),
    .ctrl_q       (ctrl_q),
    .status_q     (status_q),
    .ireq_q       (ireq_q),
    .data_active  (data_active)
);

// File: tb/sdcmd_seq_bench.sv
module sdcmd_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         card_req;
    logic [5:0]   card_idx;
    logic [31:0]  card_arg;
    logic         card_rsp_vld = 1'b0;
    logic [4:0]   card_rsp_len = '0;
    logic [127:0] card_rsp_data = '0;
    logic         rx_fifo_req = 1'b0, tx_fifo_req = 1'b0;
    logic         data_active, irq, dma_rx_req, dma_tx_req;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdcmd_seq u_sdcmd_seq (.*);

    // Table: {response type [7:6], byte count [5:1], expected good [0]}
    localparam logic [7:0] VEC [10] = '{
        {2'd0, 5'd0,  1'b1}, {2'd1, 5'd3,  1'b0}, {2'd1, 5'd4,  1'b1},
        {2'd1, 5'd7,  1'b1}, {2'd2, 5'd15, 1'b0}, {2'd2, 5'd16, 1'b1},
        {2'd3, 5'd4,  1'b1}, {2'd3, 5'd2,  1'b0}, {2'd0, 5'd5,  1'b1},
        {2'd2, 5'd4,  1'b0}
    };

    function automatic logic [7:0] bval(input int i, input int k);
        return 8'((k * 29 + i * 7 + 3) & 255);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic respond(input int i, input logic [4:0] len);
        card_rsp_data = '0;
        for (int k = 0; k < 16; k++) card_rsp_data[k*8 +: 8] = bval(i, k);
        card_rsp_vld = 1'b1; card_rsp_len = len;
        @(negedge clk);
        card_rsp_vld = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(4'd1, d); chk("R12 status", d, 16'h0);
        rd(4'd7, d); chk("R12 ireq", d, 16'h0);
        chk("R12 irq/req/data", {irq, card_req, data_active}, 3'b000);
        rd(4'd2, d); chk("R1 cmd reset read", d, 16'h0040);

        // R1 / R2 index and argument halves
        wr(4'd2, 16'hffd5); rd(4'd2, d); chk("R1 cmd read", d, 16'h0055);
        wr(4'd3, 16'hdead); wr(4'd4, 16'hbeef);
        wr(4'd3, 16'h1234);
        chk("R2 arg high rewrite", card_arg, 32'h1234beef);
        wr(4'd4, 16'h5678);
        chk("R2 arg low rewrite", card_arg, 32'h12345678);

        // R3 pending while clock off, R4 start launches
        wr(4'd5, 16'h0001);
        chk("R3 no req clock off", card_req, 1'b0);
        @(negedge clk); chk("R3 still no req", card_req, 1'b0);
        wr(4'd0, 16'h0002);
        chk("R4 start launches", card_req, 1'b1);
        chk("R1 idx on channel", card_idx, 6'h15);
        @(negedge clk); chk("R3 req one cycle", card_req, 1'b0);
        rd(4'd1, d); chk("R4 clken set", d, 16'h0100);
        rd(4'd7, d); chk("R4 clkoff clear", d[4], 1'b0);
        respond(99, 5'd4);

        // Table walk: length check and unpacking
        for (int i = 0; i < 10; i++) begin
            logic [1:0] ty; logic [4:0] ln; logic ok;
            logic [15:0] ex;
            ty = VEC[i][7:6]; ln = VEC[i][5:1]; ok = VEC[i][0];
            wr(4'd5, {14'd0, ty});
            chk("R3 launch with clock on", card_req, 1'b1);
            respond(i, ln);
            rd(4'd1, d);
            chk(ok ? "R7 status good" : "R6 status short", d,
                ok ? 16'h2100 : 16'h0102);
            rd(4'd7, d); chk("R8 endcmd set", d[2], 1'b1);
            chk("R10 irq endcmd", irq, 1'b1);
            for (int e = 0; e < 10; e++) begin
                ex = 16'h0;
                if (ok && e < 9) begin
                    if (2*e < int'(ln))   ex[7:0]  = bval(i, 2*e);
                    if (2*e+1 < int'(ln)) ex[15:8] = bval(i, 2*e+1);
                end
                rd(4'd8, d);
                chk(ok ? "R9 entry" : "R6 entry zero", d, ex);
            end
        end

        // R3 control write clears outcome, R7 data_active
        wr(4'd5, 16'h0005);
        rd(4'd1, d); chk("R3 clear on ctl write", d, 16'h0100);
        respond(20, 5'd6);
        chk("R7 data_active", data_active, 1'b1);

        // R5 stop abandons a waiting command
        wr(4'd5, 16'h0001);
        wr(4'd0, 16'h0003);
        chk("R5 data_active low", data_active, 1'b0);
        respond(21, 5'd4);
        rd(4'd1, d); chk("R5 late response ignored", d, 16'h0000);
        rd(4'd7, d); chk("R5 clkoff set", d[4:2], 3'b100);

        // R3 hold bit keeps the command back, even at start
        wr(4'd5, 16'h0401);
        wr(4'd0, 16'h0002);
        chk("R3 hold no req", card_req, 1'b0);

        // R10 mask, R11 DMA routing
        wr(4'd0, 16'h0001);
        chk("R10 clkoff irq", irq, 1'b1);
        wr(4'd6, 16'h0010);
        chk("R10 masked", irq, 1'b0);
        @(negedge clk); rx_fifo_req = 1'b1; #1;
        chk("R10 rx irq", {irq, dma_rx_req}, 2'b10);
        wr(4'd5, 16'h0480);
        chk("R11 rx to dma", {irq, dma_rx_req, dma_tx_req}, 3'b010);
        @(negedge clk); rx_fifo_req = 1'b0; tx_fifo_req = 1'b1; #1;
        chk("R11 tx to dma", {irq, dma_rx_req, dma_tx_req}, 3'b001);
        wr(4'd5, 16'h0400);
        chk("R11 dma off", {irq, dma_tx_req}, 2'b10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule